// File: doc/BRIEF.md
# Halt and Active-Halt Power Sequencer

This block decides how a small processor core sleeps and how it wakes. When the core signals that it has executed its halt instruction, the sequencer looks at the wake-timer interrupt-enable input. If that input is set, it parks the core in ACTIVE-HALT. In that state the main oscillator keeps running so the wake timer can still count, while the CPU and peripheral clocks are gated. If the input is clear, it drops into full HALT with every clock stopped. The block drives the three clock enables and forces the core's two-bit interrupt-mask field open while it sits in ACTIVE-HALT. It also chooses between a fast wake and a wake that first waits for the oscillator to settle.

A wake-timer interrupt resumes the core at once. It then opens a settling window of 256 or 4096 cycles, selected by a static option input. If software drops the wake-timer enable inside that window, the block spends the rest of the window in full HALT. An external interrupt ends full HALT, and a reset ends either state. Both of these paths run the settling delay with only the oscillator on. The core is then told to service an interrupt or to fetch its reset vector. The `mode` output reports the current mode with a fixed encoding, so the clock enables can be checked against it.

Internally there are ten states. RUN, FETCH, SVC, WAKE and WIN all report RUN mode. HALT and WIN_HALT report HALT mode. AHALT reports ACTIVE-HALT. RST_DLY and IRQ_DLY report DELAY mode. The transitions are:
- RUN→AHALT, RUN→HALT: halt strobe.
- AHALT→WAKE: wake-timer interrupt.
- WAKE/WIN→WIN: window continues with the enable still set.
- WAKE/WIN→WIN_HALT: early clear of the enable.
- WAKE/WIN/WIN_HALT→RUN: window end.
- HALT→IRQ_DLY: external interrupt.
- IRQ_DLY→SVC: delay end.
- RST_DLY→FETCH: delay end.
- FETCH/SVC→RUN: after one cycle.
- any→RST_DLY: reset.

Top module: `pwr_halt_ctrl`

## Requirements
- R1: `mode` encodes RUN=0, HALT=1, ACTIVE-HALT=2, DELAY=3. A `halt_req` pulse in the RUN state moves to ACTIVE-HALT on the next edge when `wkt_ie`=1. When `wkt_ie`=0 and `wdg_active`=0 it moves to HALT instead. `halt_req` has no effect in any other state.
- R2: In ACTIVE-HALT, `osc_en`=1 and `cpu_clk_en`=`per_clk_en`=0.
- R3: In HALT mode, `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0. In RUN mode all three are 1.
- R4: ACTIVE-HALT is left only on `wkt_irq` or reset, and `ext_irq` is ignored there. Full HALT is left only on `ext_irq` or reset, and `wkt_irq` is ignored there.
- R5: With `wkt_irq` high in ACTIVE-HALT, the next edge gives RUN mode with `svc_irq`=1 for exactly one cycle, with no delay.
- R6: Reset (`rst_n` low, asynchronous) forces DELAY mode at once, with only `osc_en` high. After release the block stays in DELAY for L edges, where L=SHORT_DLY if `long_dly`=0 and LONG_DLY if `long_dly`=1. It then shows RUN with `fetch_rst_vec`=1 for one cycle.
- R7: While in ACTIVE-HALT, `irq_mask_wr`=1 and `irq_mask`=2'b10. A `wkt_irq` already high on entry wakes the block on the following edge.
- R8: A halt strobe in RUN with `wkt_ie`=0 and `wdg_active`=1 raises `wdg_rst_req` in the same cycle, and the block stays in RUN. With `wkt_ie`=1, `wdg_rst_req` is never raised.
- R9: The settling window after a wake-timer wake lasts L cycles, counting the wake cycle. If `wkt_ie` goes low within the window, the block is in HALT mode from the next edge until the window's end. RUN resumes on the same edge either way.
- R10: An `ext_irq` in full HALT gives DELAY mode with `osc_en`=1 for L edges. The block then shows RUN with `svc_irq`=1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| long_dly | input | 1 | Static option: 0 selects SHORT_DLY, 1 selects LONG_DLY |
| halt_req | input | 1 | One-cycle strobe from the core on a halt instruction |
| wkt_ie | input | 1 | Wake-timer interrupt enable bit |
| wkt_irq | input | 1 | Wake-timer interrupt event |
| ext_irq | input | 1 | External interrupt event |
| wdg_active | input | 1 | Watchdog is running |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Main oscillator enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| irq_mask_wr | output | 1 | Forces the core's interrupt-mask field |
| irq_mask | output | 2 | Value forced into the mask field (2'b10) |
| fetch_rst_vec | output | 1 | One-cycle pulse: core fetches the reset vector |
| svc_irq | output | 1 | One-cycle pulse: core services the pending interrupt |
| wdg_rst_req | output | 1 | Watchdog reset request for a halt strobe refused in RUN |
| mode | output | 2 | Current mode: 0 RUN, 1 HALT, 2 ACTIVE-HALT, 3 DELAY |

## Verification
The hardest situation to reach is the late drop into WIN_HALT. The core must first enter ACTIVE-HALT and be woken by the timer. The enable must then be cleared at a chosen cycle in the middle of the window, and the return to RUN must land exactly on the edge where the unchanged window would have closed. The bench walks into this with short delay parameters. It clears the enable once on the wake cycle and once three cycles later, and checks every edge up to the window's end. The already-pending wake, which is entry and exit on adjacent edges, is reached by raising the halt strobe and the wake-timer event in the same cycle.

// File: rtl/pwr_halt_pkg.sv
package pwr_halt_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_HALT  = 2'd1,
        MODE_AHALT = 2'd2,
        MODE_DELAY = 2'd3
    } pwr_mode_e;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_HALT,
        ST_AHALT,
        ST_RST_DLY,
        ST_IRQ_DLY,
        ST_FETCH,
        ST_SVC,
        ST_WAKE,
        ST_WIN,
        ST_WIN_HALT
    } pwr_state_e;

    localparam logic [1:0] IMASK_OPEN = 2'b10;

endpackage

// File: rtl/pwr_dly_cnt.sv
module pwr_dly_cnt #(
    parameter int SHORT_DLY = 256,
    parameter int LONG_DLY  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_sel,
    output logic done
);
    localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
    localparam int CW      = $clog2(MAX_DLY + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    generate
        if (SHORT_DLY == LONG_DLY) begin : g_fixed
            assign last = CW'(SHORT_DLY - 1);
        end else begin : g_select
            assign last = long_sel ? CW'(LONG_DLY - 1) : CW'(SHORT_DLY - 1);
        end
    endgenerate

    assign done = run && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwr_halt_fsm.sv
module pwr_halt_fsm
    import pwr_halt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       wkt_ie,
    input  logic       wkt_irq,
    input  logic       ext_irq,
    input  logic       wdg_active,
    input  logic       dly_done,
    output pwr_state_e state
);
    pwr_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RST_DLY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (halt_req) begin
                    if (wkt_ie) begin
                        state_nx = ST_AHALT;
                    end else if (!wdg_active) begin
                        state_nx = ST_HALT;
                    end
                end
            end
            ST_HALT:    if (ext_irq)  state_nx = ST_IRQ_DLY;
            ST_AHALT:   if (wkt_irq)  state_nx = ST_WAKE;
            ST_RST_DLY: if (dly_done) state_nx = ST_FETCH;
            ST_IRQ_DLY: if (dly_done) state_nx = ST_SVC;
            ST_FETCH:   state_nx = ST_RUN;
            ST_SVC:     state_nx = ST_RUN;
            ST_WAKE, ST_WIN: begin
                if (dly_done) begin
                    state_nx = ST_RUN;
                end else if (!wkt_ie) begin
                    state_nx = ST_WIN_HALT;
                end else begin
                    state_nx = ST_WIN;
                end
            end
            ST_WIN_HALT: if (dly_done) state_nx = ST_RUN;
            default:     state_nx = ST_RST_DLY;
        endcase
    end

endmodule

// File: rtl/pwr_halt_out.sv
module pwr_halt_out
    import pwr_halt_pkg::*;
(
    input  pwr_state_e  state,
    input  logic        halt_req,
    input  logic        wkt_ie,
    input  logic        wdg_active,
    output logic        cnt_run,
    output logic        cpu_clk_en,
    output logic        osc_en,
    output logic        per_clk_en,
    output logic        irq_mask_wr,
    output logic        fetch_rst_vec,
    output logic        svc_irq,
    output logic        wdg_rst_req,
    output pwr_mode_e   mode
);
    always_comb begin
        cpu_clk_en    = 1'b0;
        osc_en        = 1'b0;
        per_clk_en    = 1'b0;
        irq_mask_wr   = 1'b0;
        fetch_rst_vec = 1'b0;
        svc_irq       = 1'b0;
        cnt_run       = 1'b0;
        mode          = MODE_RUN;
        unique case (state)
            ST_RUN, ST_FETCH, ST_SVC, ST_WAKE, ST_WIN: begin
                cpu_clk_en    = 1'b1;
                osc_en        = 1'b1;
                per_clk_en    = 1'b1;
                fetch_rst_vec = (state == ST_FETCH);
                svc_irq       = (state == ST_SVC) || (state == ST_WAKE);
                cnt_run       = (state == ST_WAKE) || (state == ST_WIN);
            end
            ST_HALT, ST_WIN_HALT: begin
                mode    = MODE_HALT;
                cnt_run = (state == ST_WIN_HALT);
            end
            ST_AHALT: begin
                mode        = MODE_AHALT;
                osc_en      = 1'b1;
                irq_mask_wr = 1'b1;
            end
            ST_RST_DLY, ST_IRQ_DLY: begin
                mode    = MODE_DELAY;
                osc_en  = 1'b1;
                cnt_run = 1'b1;
            end
            default: mode = MODE_DELAY;
        endcase
    end

    assign wdg_rst_req = (state == ST_RUN) && halt_req && !wkt_ie && wdg_active;

endmodule

// File: rtl/pwr_halt_ctrl.sv
module pwr_halt_ctrl
    import pwr_halt_pkg::*;
#(
    parameter int SHORT_DLY = 256,
    parameter int LONG_DLY  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       long_dly,
    input  logic       halt_req,
    input  logic       wkt_ie,
    input  logic       wkt_irq,
    input  logic       ext_irq,
    input  logic       wdg_active,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       per_clk_en,
    output logic       irq_mask_wr,
    output logic [1:0] irq_mask,
    output logic       fetch_rst_vec,
    output logic       svc_irq,
    output logic       wdg_rst_req,
    output logic [1:0] mode
);
    pwr_state_e state;
    pwr_mode_e  mode_e;
    logic       cnt_run;
    logic       dly_done;

    pwr_halt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .wkt_ie     (wkt_ie),
        .wkt_irq    (wkt_irq),
        .ext_irq    (ext_irq),
        .wdg_active (wdg_active),
        .dly_done   (dly_done),
        .state      (state)
    );

    pwr_dly_cnt #(
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cnt_run),
        .long_sel (long_dly),
        .done     (dly_done)
    );

    pwr_halt_out u_out (
        .state         (state),
        .halt_req      (halt_req),
        .wkt_ie        (wkt_ie),
        .wdg_active    (wdg_active),
        .cnt_run       (cnt_run),
        .cpu_clk_en    (cpu_clk_en),
        .osc_en        (osc_en),
        .per_clk_en    (per_clk_en),
        .irq_mask_wr   (irq_mask_wr),
        .fetch_rst_vec (fetch_rst_vec),
        .svc_irq       (svc_irq),
        .wdg_rst_req   (wdg_rst_req),
        .mode          (mode_e)
    );

    assign irq_mask = IMASK_OPEN;
    assign mode     = mode_e;

endmodule

// File: rtl/pwr_halt_chk.sv
module pwr_halt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wkt_ie,
    input logic       wkt_irq,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic       per_clk_en,
    input logic       irq_mask_wr,
    input logic [1:0] irq_mask,
    input logic       fetch_rst_vec,
    input logic       svc_irq,
    input logic       wdg_rst_req,
    input logic [1:0] mode
);
    // R2: in ACTIVE-HALT only the oscillator stays enabled
    a_r2_ahalt_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (osc_en && !cpu_clk_en && !per_clk_en));

    // R3: full HALT gates every clock
    a_r3_halt_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (!osc_en && !cpu_clk_en && !per_clk_en));

    // R4: without a wake-timer event ACTIVE-HALT persists
    a_r4_ahalt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !wkt_irq) |=> (mode == 2'd2));

    // R5: wake-timer event resumes at once with a service pulse
    a_r5_fast_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && wkt_irq) |=> (mode == 2'd0 && svc_irq));

    // R6: reset-vector fetch only follows a delay period
    a_r6_fetch_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rst_vec |-> ($past(mode) == 2'd3));

    // R7: mask field forced open throughout ACTIVE-HALT
    a_r7_mask_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (irq_mask_wr && irq_mask == 2'b10));

    // R8: no watchdog reset request while the wake-timer enable is set
    a_r8_no_wdg_req: assert property (@(posedge clk) disable iff (!rst_n)
        wkt_ie |-> !wdg_rst_req);

    // R10: service pulse only after ACTIVE-HALT or a delay period
    a_r10_svc_source: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |-> ($past(mode) == 2'd2 || $past(mode) == 2'd3));

    // R5/R6: the two resume indications never coincide
    a_r6_one_resume: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_rst_vec, svc_irq}));

endmodule

bind pwr_halt_ctrl pwr_halt_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wkt_ie        (wkt_ie),
    .wkt_irq       (wkt_irq),
    .cpu_clk_en    (cpu_clk_en),
    .osc_en        (osc_en),
    .per_clk_en    (per_clk_en),
    .irq_mask_wr   (irq_mask_wr),
    .irq_mask      (irq_mask),
    .fetch_rst_vec (fetch_rst_vec),
    .svc_irq       (svc_irq),
    .wdg_rst_req   (wdg_rst_req),
    .mode          (mode)
);

// File: tb/pwr_halt_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_halt_ctrl_tb;
    localparam int LIM_S = 8;
    localparam int LIM_L = 20;
    localparam logic [1:0] M_RUN = 2'd0, M_HALT = 2'd1, M_AH = 2'd2, M_DLY = 2'd3;

    // vector: {halt, ie, wkt, ext, wdg} , {mode, cpu, osc, per, fetch, svc, wdg_req}
    localparam int NV = 25;
    localparam logic [12:0] VEC [NV] = '{
        {5'b01000, 8'b00_111_00_0},  // R3 RUN idle
        {5'b11000, 8'b10_010_00_0},  // R1/R2 enter ACTIVE-HALT
        {5'b01010, 8'b10_010_00_0},  // R4 ext ignored
        {5'b01100, 8'b00_111_01_0},  // R5 wake-timer wake
        {5'b01000, 8'b00_111_00_0},  // R9 window
        {5'b01000, 8'b00_111_00_0},
        {5'b01000, 8'b00_111_00_0},
        {5'b01000, 8'b00_111_00_0},
        {5'b01000, 8'b00_111_00_0},
        {5'b01000, 8'b00_111_00_0},
        {5'b01000, 8'b00_111_00_0},
        {5'b01000, 8'b00_111_00_0},
        {5'b10001, 8'b00_111_00_1},  // R8 refused halt
        {5'b10000, 8'b01_000_00_0},  // R1/R3 enter HALT
        {5'b00100, 8'b01_000_00_0},  // R4 wkt ignored in HALT
        {5'b00010, 8'b11_010_00_0},  // R10 ext wake, delay
        {5'b00000, 8'b11_010_00_0},
        {5'b00000, 8'b11_010_00_0},
        {5'b00000, 8'b11_010_00_0},
        {5'b00000, 8'b11_010_00_0},
        {5'b00000, 8'b11_010_00_0},
        {5'b00000, 8'b11_010_00_0},
        {5'b00000, 8'b11_010_00_0},
        {5'b00000, 8'b00_111_01_0},  // R10 service pulse
        {5'b00000, 8'b00_111_00_0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic long_dly = 1'b0;
    logic halt_req = 1'b0, wkt_ie = 1'b0, wkt_irq = 1'b0, ext_irq = 1'b0, wdg_active = 1'b0;
    logic cpu_clk_en, osc_en, per_clk_en, irq_mask_wr, fetch_rst_vec, svc_irq, wdg_rst_req;
    logic [1:0] irq_mask, mode;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_halt_ctrl #(.SHORT_DLY(LIM_S), .LONG_DLY(LIM_L)) u_dut (
        .clk(clk), .rst_n(rst_n), .long_dly(long_dly), .halt_req(halt_req),
        .wkt_ie(wkt_ie), .wkt_irq(wkt_irq), .ext_irq(ext_irq), .wdg_active(wdg_active),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .per_clk_en(per_clk_en),
        .irq_mask_wr(irq_mask_wr), .irq_mask(irq_mask), .fetch_rst_vec(fetch_rst_vec),
        .svc_irq(svc_irq), .wdg_rst_req(wdg_rst_req), .mode(mode)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    task automatic reset_seq(input int lim);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R6 reset mode", 32'(mode), 32'(M_DLY));
        chk("R6 reset clocks", 32'({cpu_clk_en, osc_en, per_clk_en}), 32'(3'b010));
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= lim; k++) begin
            edge_wait();
            if (k < lim) chk("R6 delay", 32'(mode), 32'(M_DLY));
            else chk("R6 fetch", 32'({mode, fetch_rst_vec}), 32'({M_RUN, 1'b1}));
        end
        edge_wait();
        chk("R6 fetch single", 32'(fetch_rst_vec), 32'd0);
    endtask

    initial begin
        reset_seq(LIM_S);

        // table walk, short delay
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {halt_req, wkt_ie, wkt_irq, ext_irq, wdg_active} = VEC[i][12:8];
            #1;
            chk($sformatf("R8 row %0d wdg_rst_req", i), 32'(wdg_rst_req), 32'(VEC[i][0]));
            edge_wait();
            chk($sformatf("R1-table row %0d outputs", i),
                32'({mode, cpu_clk_en, osc_en, per_clk_en, fetch_rst_vec, svc_irq}),
                32'(VEC[i][7:1]));
        end

        // R8 and R7: watchdog active, enable set
        @(negedge clk);
        {halt_req, wkt_ie, wkt_irq, ext_irq, wdg_active} = 5'b11001;
        #1;
        chk("R8 no req with enable", 32'(wdg_rst_req), 32'd0);
        edge_wait();
        chk("R7 mask forced", 32'({mode, irq_mask_wr, irq_mask}), 32'({M_AH, 1'b1, 2'b10}));
        @(negedge clk);
        {halt_req, wkt_ie, wkt_irq, ext_irq, wdg_active} = 5'b11100;
        edge_wait();
        chk("R5 wake", 32'({mode, svc_irq}), 32'({M_RUN, 1'b1}));
        // R9: clear enable on the wake cycle
        @(negedge clk);
        {halt_req, wkt_ie, wkt_irq} = 3'b000;
        for (int k = 1; k <= LIM_S; k++) begin
            edge_wait();
            if (k < LIM_S) begin
                chk("R9 early clear halt", 32'(mode), 32'(M_HALT));
                chk("R3 halt clocks", 32'({cpu_clk_en, osc_en, per_clk_en}), 32'd0);
            end else begin
                chk("R9 resume at window end", 32'(mode), 32'(M_RUN));
            end
        end

        // R7: wake already pending on entry
        @(negedge clk);
        {halt_req, wkt_ie, wkt_irq} = 3'b111;
        edge_wait();
        chk("R7 pending entry", 32'(mode), 32'(M_AH));
        @(negedge clk);
        halt_req = 1'b0;
        edge_wait();
        chk("R7 pending wake next", 32'({mode, svc_irq}), 32'({M_RUN, 1'b1}));
        wkt_irq = 1'b0;
        // R9: clear enable three cycles into the window
        for (int k = 1; k <= LIM_S; k++) begin
            @(negedge clk);
            if (k == 3) wkt_ie = 1'b0;
            edge_wait();
            if (k < 3 || k == LIM_S) chk("R9 late clear run", 32'(mode), 32'(M_RUN));
            else chk("R9 late clear halt", 32'(mode), 32'(M_HALT));
        end

        // R6: asynchronous reset inside ACTIVE-HALT
        @(negedge clk);
        {halt_req, wkt_ie} = 2'b11;
        edge_wait();
        @(negedge clk);
        halt_req = 1'b0;
        #2;
        rst_n = 1'b0;
        #1;
        chk("R6 async reset priority", 32'(mode), 32'(M_DLY));

        // R6 long delay
        long_dly = 1'b1;
        wkt_ie = 1'b0;
        reset_seq(LIM_L);

        // R1: halt strobe ignored in HALT; R10 long delay
        @(negedge clk);
        halt_req = 1'b1;
        edge_wait();
        chk("R1 enter halt", 32'(mode), 32'(M_HALT));
        @(negedge clk);
        wkt_ie = 1'b1;
        edge_wait();
        chk("R1 strobe ignored in HALT", 32'(mode), 32'(M_HALT));
        @(negedge clk);
        {halt_req, wkt_ie, ext_irq} = 3'b001;
        edge_wait();
        chk("R10 delay entry", 32'({mode, osc_en, cpu_clk_en}), 32'({M_DLY, 2'b10}));
        @(negedge clk);
        ext_irq = 1'b0;
        for (int k = 1; k <= LIM_L; k++) begin
            edge_wait();
            if (k < LIM_L) chk("R10 long delay", 32'(mode), 32'(M_DLY));
            else chk("R10 service after delay", 32'({mode, svc_irq}), 32'({M_RUN, 1'b1}));
        end
        edge_wait();
        chk("R10 service single", 32'(svc_irq), 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule